// File: doc/BRIEF.md
# Parallel ADC Sample Reader

This block sequences one acquisition on a sixteen-bit parallel converter bus and turns the bus words into channel samples. A request starts a frame. The block drops its active-low convert output for one clock. It then waits for the converter's busy line to go high and come back low. After that it opens a chip-select window and clocks out one read-strobe pulse per bus word. Channels are read in order, first to eighth.

Static mode inputs decide how the bus words are packed. A sample is either 16 or 18 bits wide. An 18-bit sample spans two reads. An 8-bit status byte can be added for each channel, and a CRC word can follow the last channel. Each reassembled sample, status byte and CRC word leaves the block on its own port with a one-clock valid pulse. A flag marks the sample of the first channel in each frame. A request that arrives while a frame is in progress is kept and served once the frame ends.

Top module: `adc_par_reader`

## Requirements
- R1: While reset is held and after reset is released, `adcConvN`, `adcCsN` and `adcRdN` are high and `smpValid`, `statValid` and `crcValid` are low until a request arrives.
- R2: A request drives `adcConvN` low for exactly one clock. `adcCsN` falls only after `adcBusy` has been seen high and then low again.
- R3: Each read-strobe low phase lasts `cfgLowWidth` clocks and each high phase between two reads lasts `cfgHighWidth` clocks, with a setting of 0 treated as 1. The bus is captured at the clock edge where `adcRdN` rises.
- R4: A frame contains 8 reads per word-per-channel plus one read if CRC is on. Words per channel are 2 when `cfgWide` or `cfgStatus` is set, otherwise 1. `adcCsN` goes high after the last read, and `adcRdN` stays low only while `adcCsN` is low.
- R5: With `cfgWide`=0, every channel's data word is output zero-extended as `{2'b00, word}`, in channel order. `smpFirst` is 1 only on the first channel's sample.
- R6: With `cfgWide`=1, the first read of a channel carries sample bits 17..2. The sample is `{first word, second word[15:14]}`, and bits 13..8 of the second word are ignored.
- R7: With `cfgStatus`=1, the status byte is bits 7..0 of the channel's second word. In 16-bit mode the sample is output one read before its status. In 18-bit mode the sample and the status are output in the same clock.
- R8: With `cfgCrc`=1, the word read after the last channel appears on `crcData` with a one-clock `crcValid`, and never in the same clock as `smpValid`.
- R9: Each valid pulse lasts one clock per captured item, so `smpValid` is never high on two consecutive clocks.
- R10: A request made while a frame is being read is held and starts exactly one further frame after the current frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| convReq | input | 1 | One-clock request to acquire a frame |
| cfgWide | input | 1 | 1: 18-bit samples over two reads |
| cfgStatus | input | 1 | 1: status byte per channel |
| cfgCrc | input | 1 | 1: trailing CRC word |
| cfgLowWidth | input | 8 | Read-strobe low clocks |
| cfgHighWidth | input | 8 | Read-strobe high clocks between reads |
| adcBusy | input | 1 | Converter busy flag |
| adcData | input | 16 | Parallel data bus |
| adcConvN | output | 1 | Active-low convert strobe |
| adcCsN | output | 1 | Active-low chip select |
| adcRdN | output | 1 | Active-low read strobe |
| smpValid | output | 1 | Sample valid pulse |
| smpData | output | 18 | Reassembled sample |
| smpFirst | output | 1 | Sample belongs to first channel |
| statValid | output | 1 | Status valid pulse |
| statData | output | 8 | Channel status byte |
| crcValid | output | 1 | CRC word valid pulse |
| crcData | output | 16 | CRC word as read |

## Verification
In 18-bit mode with status enabled, the channel's second read completes the sample and delivers the status byte at the same edge. `smpValid` and `statValid` therefore rise together, and both values must come from that one bus word. The bench provokes this with random sample and status bits, plus junk in the unused middle bits. On every clock it pops its expected sample and status queues independently. A merged or shifted field then shows up as a miscompare on one port while the other still matches. It also runs 16-bit status mode, where the same two items must arrive one read apart.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CONV, ST_WAIT_HI, ST_WAIT_LO, ST_RD_LOW, ST_RD_HIGH
  } rdState_t;

  typedef struct packed {
    logic start;
    logic capture;
  } rdStrobe_t;
endpackage

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             convReq,
  input  logic             adcBusy,
  input  logic             allRead,
  input  logic [CNT_W-1:0] cfgLowWidth,
  input  logic [CNT_W-1:0] cfgHighWidth,
  output logic             adcConvN,
  output logic             adcCsN,
  output logic             adcRdN,
  output rdStrobe_t        strobe
);
  rdState_t         state;
  logic [CNT_W-1:0] cnt;
  logic             pend;
  logic             lowDone;
  logic             highDone;

  assign lowDone        = (cnt >= cfgLowWidth);
  assign highDone       = (cnt >= cfgHighWidth);
  assign strobe.start   = (state == ST_WAIT_LO) && !adcBusy;
  assign strobe.capture = (state == ST_RD_LOW) && lowDone;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      adcConvN <= 1'b1;
      adcCsN   <= 1'b1;
      adcRdN   <= 1'b1;
      cnt      <= '0;
      pend     <= 1'b0;
    end else begin
      pend <= (state == ST_IDLE) ? 1'b0 : (pend | convReq);
      case (state)
        ST_IDLE: begin
          if (convReq || pend) begin
            adcConvN <= 1'b0;
            state    <= ST_CONV;
          end
        end
        ST_CONV: begin
          adcConvN <= 1'b1;
          state    <= ST_WAIT_HI;
        end
        ST_WAIT_HI: begin
          if (adcBusy) state <= ST_WAIT_LO;
        end
        ST_WAIT_LO: begin
          if (!adcBusy) begin
            adcCsN <= 1'b0;
            adcRdN <= 1'b0;
            cnt    <= CNT_W'(1);
            state  <= ST_RD_LOW;
          end
        end
        ST_RD_LOW: begin
          if (lowDone) begin
            adcRdN <= 1'b1;
            cnt    <= CNT_W'(1);
            state  <= ST_RD_HIGH;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_RD_HIGH: begin
          if (highDone) begin
            cnt <= CNT_W'(1);
            if (allRead) begin
              adcCsN <= 1'b1;
              state  <= ST_IDLE;
            end else begin
              adcRdN <= 1'b0;
              state  <= ST_RD_LOW;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_rd_data.sv
module adc_rd_data
  import adc_rd_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int BUS_W  = 16,
  parameter int SMP_W  = 18,
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rdStrobe_t         strobe,
  input  logic [BUS_W-1:0]  adcData,
  input  logic              cfgWide,
  input  logic              cfgStatus,
  input  logic              cfgCrc,
  output logic              allRead,
  output logic              smpValid,
  output logic [SMP_W-1:0]  smpData,
  output logic              smpFirst,
  output logic              statValid,
  output logic [STAT_W-1:0] statData,
  output logic              crcValid,
  output logic [BUS_W-1:0]  crcData
);
  localparam int CH_W  = $clog2(NUM_CH + 1);
  localparam int EXT_W = SMP_W - BUS_W;

  logic [CH_W-1:0]  chan;
  logic             phase;
  logic             crcDone;
  logic [BUS_W-1:0] hiWord;
  logic             twoWords;
  logic             chansDone;
  logic             isFirst;

  assign twoWords  = cfgWide | cfgStatus;
  assign chansDone = (chan == CH_W'(NUM_CH));
  assign isFirst   = (chan == '0);
  assign allRead   = chansDone && (!cfgCrc || crcDone);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chan      <= '0;
      phase     <= 1'b0;
      crcDone   <= 1'b0;
      hiWord    <= '0;
      smpValid  <= 1'b0;
      smpData   <= '0;
      smpFirst  <= 1'b0;
      statValid <= 1'b0;
      statData  <= '0;
      crcValid  <= 1'b0;
      crcData   <= '0;
    end else begin
      smpValid  <= 1'b0;
      statValid <= 1'b0;
      crcValid  <= 1'b0;
      if (strobe.start) begin
        chan    <= '0;
        phase   <= 1'b0;
        crcDone <= 1'b0;
      end else if (strobe.capture) begin
        if (chansDone) begin
          crcData  <= adcData;
          crcValid <= 1'b1;
          crcDone  <= 1'b1;
        end else if (!twoWords) begin
          smpData  <= {{EXT_W{1'b0}}, adcData};
          smpValid <= 1'b1;
          smpFirst <= isFirst;
          chan     <= chan + 1'b1;
        end else if (!phase) begin
          phase  <= 1'b1;
          hiWord <= adcData;
          if (!cfgWide) begin
            smpData  <= {{EXT_W{1'b0}}, adcData};
            smpValid <= 1'b1;
            smpFirst <= isFirst;
          end
        end else begin
          phase <= 1'b0;
          chan  <= chan + 1'b1;
          if (cfgWide) begin
            smpData  <= {hiWord, adcData[BUS_W-1 -: EXT_W]};
            smpValid <= 1'b1;
            smpFirst <= isFirst;
          end
          if (cfgStatus) begin
            statData  <= adcData[STAT_W-1:0];
            statValid <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/adc_par_reader.sv
module adc_par_reader
  import adc_rd_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int BUS_W  = 16,
  parameter int SMP_W  = 18,
  parameter int STAT_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              convReq,
  input  logic              cfgWide,
  input  logic              cfgStatus,
  input  logic              cfgCrc,
  input  logic [CNT_W-1:0]  cfgLowWidth,
  input  logic [CNT_W-1:0]  cfgHighWidth,
  input  logic              adcBusy,
  input  logic [BUS_W-1:0]  adcData,
  output logic              adcConvN,
  output logic              adcCsN,
  output logic              adcRdN,
  output logic              smpValid,
  output logic [SMP_W-1:0]  smpData,
  output logic              smpFirst,
  output logic              statValid,
  output logic [STAT_W-1:0] statData,
  output logic              crcValid,
  output logic [BUS_W-1:0]  crcData
);
  rdStrobe_t strobe;
  logic      allRead;

  adc_rd_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .convReq(convReq), .adcBusy(adcBusy),
    .allRead(allRead), .cfgLowWidth(cfgLowWidth), .cfgHighWidth(cfgHighWidth),
    .adcConvN(adcConvN), .adcCsN(adcCsN), .adcRdN(adcRdN), .strobe(strobe)
  );

  adc_rd_data #(.NUM_CH(NUM_CH), .BUS_W(BUS_W), .SMP_W(SMP_W), .STAT_W(STAT_W)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .adcData(adcData),
    .cfgWide(cfgWide), .cfgStatus(cfgStatus), .cfgCrc(cfgCrc),
    .allRead(allRead), .smpValid(smpValid), .smpData(smpData), .smpFirst(smpFirst),
    .statValid(statValid), .statData(statData), .crcValid(crcValid), .crcData(crcData)
  );
endmodule

// File: rtl/adc_rd_chk.sv
module adc_rd_chk (
  input logic clk,
  input logic rstN,
  input logic adcBusy,
  input logic adcConvN,
  input logic adcCsN,
  input logic adcRdN,
  input logic smpValid,
  input logic crcValid
);
  // R2
  conv_one_clock_chk: assert property (@(posedge clk) disable iff (!rstN)
    !adcConvN |=> adcConvN);

  // R2
  cs_after_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(adcCsN) |-> !adcBusy);

  // R4
  rd_inside_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    !adcRdN |-> !adcCsN);

  // R9
  smp_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    smpValid |=> !smpValid);

  // R8
  crc_apart_chk: assert property (@(posedge clk) disable iff (!rstN)
    crcValid |-> !smpValid);
endmodule

bind adc_par_reader adc_rd_chk u_chk (
  .clk(clk), .rstN(rstN), .adcBusy(adcBusy), .adcConvN(adcConvN),
  .adcCsN(adcCsN), .adcRdN(adcRdN), .smpValid(smpValid), .crcValid(crcValid)
);

// File: tb/tb_adc_par_reader.sv
module tb_adc_par_reader;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        convReq = 1'b0;
  logic        cfgWide = 1'b0, cfgStatus = 1'b0, cfgCrc = 1'b0;
  logic [7:0]  cfgLowWidth = 8'd1, cfgHighWidth = 8'd1;
  logic        adcBusy = 1'b0;
  logic [15:0] adcData = 16'h0;
  logic        adcConvN, adcCsN, adcRdN;
  logic        smpValid, smpFirst, statValid, crcValid;
  logic [17:0] smpData;
  logic [7:0]  statData;
  logic [15:0] crcData;

  adc_par_reader dut (.*);

  always #2.5 clk = ~clk;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;

  logic [15:0] words[$];
  logic [18:0] expSmp[$];
  logic [7:0]  expStat[$];
  logic [15:0] expCrc[$];
  int rdIdx = 0, readCount = 0, convPulses = 0, busyTimer = 0;
  int lowRun = 0, highRun = 0;
  logic prevRd = 1'b1, prevCs = 1'b1, prevConv = 1'b1, sawBusy = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finishRun();
    end
  end

  // converter model and per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      // converter busy model
      if (!adcConvN) begin
        busyTimer = 6;
        convPulses++;
      end else if (busyTimer > 0) busyTimer--;
      adcBusy = (busyTimer >= 1 && busyTimer <= 4);
      if (adcBusy) sawBusy = 1'b1;
      // R2: convert strobe never low twice in a row
      if (!adcConvN && !prevConv) check("R2 conv width", 2, 1);
      // R2: chip select falls only after a busy high-low sequence
      if (!adcCsN && prevCs) begin
        check("R2 cs after busy", {sawBusy, adcBusy}, 2'b10);
        sawBusy = 1'b0;
        highRun = 0;
      end
      // R3: strobe widths and data bus model
      if (!adcRdN) begin
        if (prevRd && !prevCs)
          check("R3 high width", highRun, (cfgHighWidth == 0) ? 1 : cfgHighWidth);
        lowRun++;
        highRun = 0;
        adcData = (rdIdx < words.size()) ? words[rdIdx] : 16'hDEAD;
      end else begin
        if (!prevRd) begin
          check("R3 low width", lowRun, (cfgLowWidth == 0) ? 1 : cfgLowWidth);
          rdIdx++;
          readCount++;
        end
        lowRun = 0;
        if (!adcCsN) highRun++;
      end
      // R5 R6 R7 R8: outputs against behavioural queues
      if (smpValid) begin
        if (expSmp.size() == 0) check("R5 unexpected sample", 1, 0);
        else check("R5 R6 sample", {smpFirst, smpData}, expSmp.pop_front());
      end
      if (statValid) begin
        if (expStat.size() == 0) check("R7 unexpected status", 1, 0);
        else check("R7 status", statData, expStat.pop_front());
      end
      if (crcValid) begin
        if (expCrc.size() == 0) check("R8 unexpected crc", 1, 0);
        else check("R8 crc", crcData, expCrc.pop_front());
      end
      prevRd = adcRdN;
      prevCs = adcCsN;
      prevConv = adcConvN;
    end
  end

  task automatic buildFrame();
    for (int ch = 0; ch < 8; ch++) begin
      logic [31:0] r = $urandom;
      logic [7:0]  st = r[31:24];
      logic [7:0]  junk = 8'($urandom);
      if (cfgWide) begin
        logic [17:0] s = r[17:0];
        words.push_back(s[17:2]);
        words.push_back({s[1:0], junk[5:0], cfgStatus ? st : junk});
        expSmp.push_back({ch == 0, s});
      end else begin
        words.push_back(r[15:0]);
        if (cfgStatus) words.push_back({junk, st});
        expSmp.push_back({ch == 0, 2'b00, r[15:0]});
      end
      if (cfgStatus) expStat.push_back(st);
    end
    if (cfgCrc) begin
      logic [15:0] c = 16'($urandom);
      words.push_back(c);
      expCrc.push_back(c);
    end
  endtask

  task automatic runTest(input bit wide, input bit stat, input bit crc,
                         input int low, input int high, input int frames);
    int perFrame;
    int guard;
    cfgWide = wide; cfgStatus = stat; cfgCrc = crc;
    cfgLowWidth = 8'(low); cfgHighWidth = 8'(high);
    words.delete(); expSmp.delete(); expStat.delete(); expCrc.delete();
    rdIdx = 0; readCount = 0; convPulses = 0;
    for (int f = 0; f < frames; f++) buildFrame();
    perFrame = 8 * ((wide || stat) ? 2 : 1) + (crc ? 1 : 0);
    convReq = 1'b1;
    @(negedge clk);
    convReq = 1'b0;
    if (frames == 2) begin
      // R10: second request while the first frame is being read
      while (adcCsN) @(negedge clk);
      repeat (3) @(negedge clk);
      convReq = 1'b1;
      @(negedge clk);
      convReq = 1'b0;
    end
    guard = 0;
    while ((expSmp.size() != 0 || expStat.size() != 0 || expCrc.size() != 0 || !adcCsN)
           && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    repeat (6) @(negedge clk);
    check("R4 reads per frame", readCount, perFrame * frames);
    check("R4 cs high after frame", adcCsN, 1);
    check("R10 frames run", convPulses, frames);
    check("R5 samples drained", expSmp.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset strobes", {adcConvN, adcCsN, adcRdN}, 3'b111);
    check("R1 reset valids", {smpValid, statValid, crcValid}, 3'b000);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 idle strobes", {adcConvN, adcCsN, adcRdN}, 3'b111);
    check("R1 idle valids", {smpValid, statValid, crcValid}, 3'b000);

    runTest(0, 0, 0, 1, 1, 1);   // R5 plain 16-bit
    runTest(0, 1, 1, 2, 3, 1);   // R7 R8 16-bit with status and crc
    runTest(1, 0, 0, 1, 2, 1);   // R6 18-bit, junk in ignored bits
    runTest(1, 1, 1, 3, 1, 1);   // R6 R7 R8 18-bit with status and crc
    runTest(0, 0, 1, 0, 0, 1);   // R3 zero widths act as one
    runTest(0, 0, 0, 2, 2, 2);   // R10 held request
    runTest(1, 1, 0, 1, 1, 2);   // R9 back-to-back with simultaneous outputs
    finishRun();
  end
endmodule